// File: doc/BRIEF.md
# Streaming Spectrum Peak Frequency Estimator

This block sits behind a streaming FFT and takes one complex spectral bin per clock. For each frame it keeps a running maximum of bin power. It looks only at bins whose power is above a programmable noise floor. When the frame's final bin has been accepted, it reports four things:

- the winning bin number;
- the winning bin's power;
- a no-peak flag;
- an absolute frequency estimate in hertz.

The estimate is the winning bin mapped to a signed baseband frequency, plus a known oscillator offset. The oscillator offset is the local-oscillator frequency applied ahead of the FFT. Adding it turns a baseband tone position back into an absolute tone frequency.

The bin number is taken from the index sideband that travels with each beat, so the FFT may deliver bins in any order. Frames may follow each other with no idle cycle between them.

Top module: `fft_peak_freq_est`

## Requirements
- R1: Only beats with `s_valid` high are processed; while `s_valid` is low, `s_data`, `s_index` and `s_last` have no effect.
- R2: Each beat's real part is the signed 27-bit field `s_data[26:0]` and its imaginary part is the signed 27-bit field `s_data[58:32]`; bits 63:59 and 31:27 are ignored.
- R3: The bin number of a beat is the 10-bit value on `s_index`, whatever order the beats arrive in.
- R4: The reported peak is the bin with the strictly largest power re*re+im*im, computed exactly as a 55-bit unsigned value and reported on `peak_power`; on equal power the bin that arrived earlier in the frame wins.
- R5: A bin is a candidate only if its power is strictly greater than `thresh`. If no bin of a frame qualifies, `peak_none` is 1, `peak_index` is 0, `peak_power` is 0 and `peak_freq_hz` equals the offset.
- R6: `peak_freq_hz` is a signed 40-bit value equal to sb*20000 + offset. Here sb is the index for indices 0..511, and the index minus 1024 for indices 512..1023.
- R7: The offset used for a frame is the value on `osc_offset_hz` in the cycle of that frame's last beat.
- R8: `peak_valid` is high for exactly one cycle, two clock cycles after the cycle in which the last beat (`s_valid` and `s_last` high) is accepted. The running maximum restarts with the next beat, so back-to-back frames each give their own result.
- R9: While `rst_n` is low, `peak_valid` is 0 and all result outputs are 0. A frame that is cut off by reset yields no result and leaves no trace in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 64 | Packed complex bin |
| s_index | input | 10 | Bin number of this beat |
| s_valid | input | 1 | Beat present |
| s_last | input | 1 | Final beat of the frame |
| thresh | input | 55 | Noise floor; power must exceed it |
| osc_offset_hz | input | 40 | Signed oscillator offset in Hz |
| peak_valid | output | 1 | One-cycle result strobe |
| peak_none | output | 1 | No bin exceeded the floor |
| peak_index | output | 10 | Winning bin number |
| peak_power | output | 55 | Winning bin power |
| peak_freq_hz | output | 40 | Signed absolute frequency estimate in Hz |

## Verification
Two things can fall in the same cycle: the result of one frame leaving the pipeline, and the first beats of the next frame arriving, whose new offset and floor must not leak into the finished result. The stimulus table is sent as an unbroken run of frames, with the offset and the floor changed on the very first beat after each last beat. Each reported frequency and no-peak flag is then judged against the values that applied to its own frame, and each strobe must land exactly two cycles after its frame's final beat.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
   localparam int unsigned DEF_WORD_W = 64;
   localparam int unsigned DEF_CW     = 27;
   localparam int unsigned DEF_RE_LSB = 0;
   localparam int unsigned DEF_IM_LSB = 32;
   localparam int unsigned DEF_NFFT   = 1024;
   localparam int unsigned DEF_BIN_HZ = 20000;
   localparam int unsigned DEF_OFF_W  = 40;
endpackage

// File: rtl/fpe_power.sv
module fpe_power
   import fpe_pkg::*;
#(
   parameter int unsigned WORD_W = DEF_WORD_W,
   parameter int unsigned CW     = DEF_CW,
   parameter int unsigned RE_LSB = DEF_RE_LSB,
   parameter int unsigned IM_LSB = DEF_IM_LSB,
   localparam int unsigned PWR_W = 2 * CW + 1
) (
   input  logic [WORD_W-1:0] word,
   output logic [PWR_W-1:0]  pwr
);
   generate
      if (RE_LSB + CW > WORD_W || IM_LSB + CW > WORD_W) begin : g_bad_field
         $error("component field outside data word");
      end
   endgenerate

   logic [2*CW-1:0] sq [2];

   // lane 0 = real, lane 1 = imaginary
   generate
      for (genvar ln = 0; ln < 2; ln++) begin : g_lane
         localparam int unsigned LSB = (ln == 0) ? RE_LSB : IM_LSB;
         logic signed [CW-1:0]   comp;
         logic signed [2*CW-1:0] prod;
         assign comp   = word[LSB +: CW];
         assign prod   = comp * comp;
         assign sq[ln] = prod;
      end
   endgenerate

   assign pwr = {1'b0, sq[0]} + {1'b0, sq[1]};
endmodule

// File: rtl/fpe_tracker.sv
module fpe_tracker #(
   parameter int unsigned IDX_W = 10,
   parameter int unsigned PWR_W = 55,
   parameter int unsigned OFF_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_valid,
   input  logic             beat_last,
   input  logic [IDX_W-1:0] beat_idx,
   input  logic [PWR_W-1:0] beat_pwr,
   input  logic [PWR_W-1:0] thresh,
   input  logic [OFF_W-1:0] offset_in,
   output logic             done,
   output logic             fin_found,
   output logic [IDX_W-1:0] fin_idx,
   output logic [PWR_W-1:0] fin_pwr,
   output logic [OFF_W-1:0] fin_off
);
   logic             first_q;
   logic             run_found;
   logic [IDX_W-1:0] run_idx;
   logic [PWR_W-1:0] run_pwr;

   logic             base_found, take, nxt_found;
   logic [IDX_W-1:0] base_idx, nxt_idx;
   logic [PWR_W-1:0] base_pwr, nxt_pwr;

   always_comb begin
      base_found = first_q ? 1'b0 : run_found;
      base_idx   = first_q ? '0 : run_idx;
      base_pwr   = first_q ? '0 : run_pwr;
      // strict compare: an equal later bin never displaces the holder
      take       = (beat_pwr > thresh) && (!base_found || beat_pwr > base_pwr);
      nxt_found  = base_found | take;
      nxt_idx    = take ? beat_idx : base_idx;
      nxt_pwr    = take ? beat_pwr : base_pwr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q   <= 1'b1;
         run_found <= 1'b0;
         run_idx   <= '0;
         run_pwr   <= '0;
         done      <= 1'b0;
         fin_found <= 1'b0;
         fin_idx   <= '0;
         fin_pwr   <= '0;
         fin_off   <= '0;
      end else begin
         done <= beat_valid && beat_last;
         if (beat_valid) begin
            first_q   <= beat_last;
            run_found <= nxt_found;
            run_idx   <= nxt_idx;
            run_pwr   <= nxt_pwr;
            if (beat_last) begin
               fin_found <= nxt_found;
               fin_idx   <= nxt_idx;
               fin_pwr   <= nxt_pwr;
               fin_off   <= offset_in;
            end
         end
      end
   end

   // R4: within a frame the held maximum never shrinks
   p_runmax_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last && !first_q && run_found)
      |=> (run_found && run_pwr >= $past(run_pwr)));

   // R9: reset leaves the next beat starting a fresh frame
   p_fresh_after_reset_r9: assert property (@(posedge clk)
      !rst_n |=> first_q);
endmodule

// File: rtl/fpe_freq_map.sv
module fpe_freq_map #(
   parameter int unsigned IDX_W           = 10,
   parameter int unsigned PWR_W           = 55,
   parameter int unsigned OFF_W           = 40,
   parameter int unsigned NFFT            = 1024,
   parameter int unsigned BIN_HZ          = 20000,
   parameter bit          SIGNED_SPECTRUM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_done,
   input  logic             in_found,
   input  logic [IDX_W-1:0] in_idx,
   input  logic [PWR_W-1:0] in_pwr,
   input  logic [OFF_W-1:0] in_off,
   output logic             out_valid,
   output logic             out_none,
   output logic [IDX_W-1:0] out_idx,
   output logic [PWR_W-1:0] out_pwr,
   output logic [OFF_W-1:0] out_freq
);
   localparam int unsigned HALF = NFFT / 2;
   localparam logic signed [OFF_W-1:0] NFFT_S = OFF_W'(NFFT);
   localparam logic signed [OFF_W-1:0] BIN_S  = OFF_W'(BIN_HZ);

   generate
      if (NFFT != (1 << IDX_W)) begin : g_bad_len
         $error("NFFT must equal 2**IDX_W");
      end
      if (OFF_W <= IDX_W) begin : g_bad_off
         $error("offset width too small");
      end
   endgenerate

   logic signed [OFF_W-1:0] idx_ext, sbin, freq_nx;

   assign idx_ext = $signed({{(OFF_W-IDX_W){1'b0}}, in_idx});

   generate
      if (SIGNED_SPECTRUM) begin : g_wrap
         assign sbin = (in_idx >= IDX_W'(HALF)) ? idx_ext - NFFT_S : idx_ext;
      end else begin : g_plain
         assign sbin = idx_ext;
      end
   endgenerate

   assign freq_nx = sbin * BIN_S + $signed(in_off);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_none  <= 1'b0;
         out_idx   <= '0;
         out_pwr   <= '0;
         out_freq  <= '0;
      end else begin
         out_valid <= in_done;
         if (in_done) begin
            out_none <= !in_found;
            out_idx  <= in_idx;
            out_pwr  <= in_pwr;
            out_freq <= freq_nx;
         end
      end
   end

   // R5: an empty frame reports bin 0 with zero power
   p_none_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_none) |-> (out_idx == '0 && out_pwr == '0));

   // R5: an empty frame reports the offset alone
   p_none_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_done && !in_found) |=> (out_freq == $past(in_off)));
endmodule

// File: rtl/fft_peak_freq_est.sv
module fft_peak_freq_est
   import fpe_pkg::*;
#(
   parameter int unsigned WORD_W = DEF_WORD_W,
   parameter int unsigned CW     = DEF_CW,
   parameter int unsigned RE_LSB = DEF_RE_LSB,
   parameter int unsigned IM_LSB = DEF_IM_LSB,
   parameter int unsigned NFFT   = DEF_NFFT,
   parameter int unsigned BIN_HZ = DEF_BIN_HZ,
   parameter int unsigned OFF_W  = DEF_OFF_W,
   localparam int unsigned IDX_W = $clog2(NFFT),
   localparam int unsigned PWR_W = 2 * CW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] s_data,
   input  logic [IDX_W-1:0]  s_index,
   input  logic              s_valid,
   input  logic              s_last,
   input  logic [PWR_W-1:0]  thresh,
   input  logic [OFF_W-1:0]  osc_offset_hz,
   output logic              peak_valid,
   output logic              peak_none,
   output logic [IDX_W-1:0]  peak_index,
   output logic [PWR_W-1:0]  peak_power,
   output logic [OFF_W-1:0]  peak_freq_hz
);
   logic [PWR_W-1:0] beat_pwr;
   logic             done, fin_found;
   logic [IDX_W-1:0] fin_idx;
   logic [PWR_W-1:0] fin_pwr;
   logic [OFF_W-1:0] fin_off;

   fpe_power #(
      .WORD_W(WORD_W), .CW(CW), .RE_LSB(RE_LSB), .IM_LSB(IM_LSB)
   ) u_power (
      .word (s_data),
      .pwr  (beat_pwr)
   );

   fpe_tracker #(
      .IDX_W(IDX_W), .PWR_W(PWR_W), .OFF_W(OFF_W)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (s_valid),
      .beat_last  (s_last),
      .beat_idx   (s_index),
      .beat_pwr   (beat_pwr),
      .thresh     (thresh),
      .offset_in  (osc_offset_hz),
      .done       (done),
      .fin_found  (fin_found),
      .fin_idx    (fin_idx),
      .fin_pwr    (fin_pwr),
      .fin_off    (fin_off)
   );

   fpe_freq_map #(
      .IDX_W(IDX_W), .PWR_W(PWR_W), .OFF_W(OFF_W),
      .NFFT(NFFT), .BIN_HZ(BIN_HZ), .SIGNED_SPECTRUM(1'b1)
   ) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_done   (done),
      .in_found  (fin_found),
      .in_idx    (fin_idx),
      .in_pwr    (fin_pwr),
      .in_off    (fin_off),
      .out_valid (peak_valid),
      .out_none  (peak_none),
      .out_idx   (peak_index),
      .out_pwr   (peak_power),
      .out_freq  (peak_freq_hz)
   );

   // R8: the strobe follows the accepted last beat by two cycles
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_last) |=> ##1 peak_valid);

   // R8: no strobe without a last beat two cycles before
   p_no_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_valid && s_last) |=> ##1 !peak_valid);

   // R9: outputs are quiet in reset
   p_reset_quiet_r9: assert property (@(posedge clk)
      !rst_n |=> (!peak_valid && peak_index == '0 && peak_power == '0));
endmodule

// File: tb/sim_fft_peak_freq_est.sv
`timescale 1ns/1ps
module sim_fft_peak_freq_est;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] s_data = '0;
   logic [9:0]  s_index = '0;
   logic        s_valid = 1'b0;
   logic        s_last = 1'b0;
   logic [54:0] thresh = '0;
   logic [39:0] osc_offset_hz = '0;
   logic        peak_valid, peak_none;
   logic [9:0]  peak_index;
   logic [54:0] peak_power;
   logic [39:0] peak_freq_hz;

   fft_peak_freq_est u0 (
      .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_index(s_index),
      .s_valid(s_valid), .s_last(s_last), .thresh(thresh),
      .osc_offset_hz(osc_offset_hz), .peak_valid(peak_valid),
      .peak_none(peak_none), .peak_index(peak_index),
      .peak_power(peak_power), .peak_freq_hz(peak_freq_hz)
   );

   always #4 clk = ~clk;

   int     n_chk = 0, n_bad = 0;
   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // expected results queue
   int     n_exp = 0, n_got = 0;
   int     e_idx  [0:31];
   longint e_pwr  [0:31];
   longint e_frq  [0:31];
   bit     e_none [0:31];
   longint e_cyc  [0:31];
   string  e_tag  [0:31];

   typedef struct packed {
      int     pk;
      int     re;
      int     im;
      longint thr;
      longint off;
      int     eidx;
      int     enone;
   } vec_t;

   // offsets and floors change between neighbours: R7 / R5 at frame boundaries
   localparam vec_t TBL [7] = '{
      '{150, 1000, -500, 100, 32000000, 150, 0},
      '{511, -67108864, -67108864, 9, 0, 511, 0},
      '{512, 3, 4, 9, 0, 512, 0},
      '{1023, 0, 700, 9, -5000000, 1023, 0},
      '{0, 50, 50, 9, 100, 0, 0},
      '{700, 10, 0, 100, 32000000, 0, 1},
      '{300, 11, 0, 100, 0, 300, 0}
   };

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   function automatic logic [63:0] pack(input int re, input int im);
      logic [63:0] w;
      w = '1;
      w[26:0]  = re[26:0];
      w[58:32] = im[26:0];
      return w;
   endfunction

   // nb < 1024 sends a partial frame with no last beat and no expectation
   task automatic send_frame(input int pk, input int re, input int im,
                             input longint thr, input longint off,
                             input int tie, input bit gaps, input bit rev,
                             input int nb, input int eidx, input bit enone,
                             input string tag);
      for (int k = 0; k < nb; k++) begin
         int idx, r, i;
         idx = rev ? 1023 - k : k;
         r = (idx % 7) - 3;
         i = 0;
         if (idx == pk || idx == tie) begin
            r = re;
            i = im;
         end
         @(negedge clk);
         if (gaps && (k % 5 == 2)) begin
            // R1: idle cycle with huge data and last set must be ignored
            s_valid = 1'b0;
            s_last  = 1'b1;
            s_index = 10'd3;
            s_data  = pack(-67108864, 67108863);
            @(negedge clk);
         end
         s_valid = 1'b1;
         s_index = idx[9:0];
         s_data  = pack(r, i);
         s_last  = (nb == 1024) && (k == nb - 1);
         thresh  = thr[54:0];
         osc_offset_hz = off[39:0];
         if (s_last) begin
            longint sb;
            sb = (eidx >= 512) ? longint'(eidx) - 1024 : longint'(eidx);
            e_idx[n_exp]  = enone ? 0 : eidx;
            e_pwr[n_exp]  = enone ? 0 : longint'(re) * re + longint'(im) * im;
            e_frq[n_exp]  = enone ? off : sb * 20000 + off;
            e_none[n_exp] = enone;
            e_cyc[n_exp]  = cyc;
            e_tag[n_exp]  = tag;
            n_exp++;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         s_valid = 1'b0;
         s_last  = 1'b0;
      end
   endtask

   // result monitor
   always @(negedge clk) begin
      if (rst_n && peak_valid) begin
         if (n_got >= n_exp) begin
            check("R8 unexpected strobe", 1, 0);
         end else begin
            check({"R4 index ", e_tag[n_got]}, longint'(peak_index), e_idx[n_got]);
            check({"R4 power ", e_tag[n_got]}, longint'(peak_power), e_pwr[n_got]);
            check({"R6 freq ", e_tag[n_got]}, longint'($signed(peak_freq_hz)), e_frq[n_got]);
            check({"R5 none ", e_tag[n_got]}, longint'(peak_none), longint'(e_none[n_got]));
            check({"R8 latency ", e_tag[n_got]}, cyc, e_cyc[n_got] + 2);
            n_got++;
         end
      end
   end

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 reset valid", longint'(peak_valid), 0);
      check("R9 reset index", longint'(peak_index), 0);
      check("R9 reset power", longint'(peak_power), 0);
      check("R9 reset freq", longint'(peak_freq_hz), 0);
      rst_n = 1'b1;
      idle(2);

      // table, back to back (R2 sign fields, R6 wrap, R5 floor, R7, R8)
      for (int v = 0; v < 7; v++) begin
         send_frame(TBL[v].pk, TBL[v].re, TBL[v].im, TBL[v].thr, TBL[v].off,
                    -1, 1'b0, 1'b0, 1024, TBL[v].eidx, TBL[v].enone[0],
                    $sformatf("R2 R7 table[%0d]", v));
      end
      idle(5);

      // R4 tie: equal power at bins 20 and 40, earlier wins
      send_frame(40, 30, 40, 9, 0, 20, 1'b0, 1'b0, 1024, 20, 1'b0, "R4 tie");
      // R3 reversed arrival: bin 900 arrives before bin 5 with equal power
      send_frame(5, -300, 400, 9, 1000, 900, 1'b0, 1'b1, 1024, 900, 1'b0, "R3 reversed");
      // R1 frame with idle cycles carrying garbage
      send_frame(777, -2000, 1500, 9, 7000000, -1, 1'b1, 1'b0, 1024, 777, 1'b0, "R1 gaps");
      idle(5);

      // R9 reset mid-frame: large peak in a cut-off frame must vanish
      send_frame(100, 60000, 0, 9, 0, -1, 1'b0, 1'b0, 600, 0, 1'b0, "R9 partial");
      @(negedge clk);
      s_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 mid reset valid", longint'(peak_valid), 0);
      check("R9 mid reset power", longint'(peak_power), 0);
      rst_n = 1'b1;
      send_frame(50, 20, 0, 9, 0, -1, 1'b0, 1'b0, 1024, 50, 1'b0, "R9 after reset");
      idle(10);

      check("R8 result count", n_got, n_exp);
      summary();
   end
endmodule